// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block sequences a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no bypass paths. It holds the hazard-relevant fields of every instruction in flight: valid, write-enable, destination index, source indices and a trace tag. From these it decides, each cycle, whether the decode instruction may move on. A decode instruction that reads a register still owed by an older instruction waits in decode. The program counter freezes with it, and an empty slot (bubble) goes into execute in its place.

Branches and jumps are resolved in execute. When the execute stage reports a taken redirect, the two younger instructions are on the wrong path: the one being fetched and the one in decode. Both are discarded, and the redirect takes precedence over any stall raised in the same cycle. The ALU, memories, register file and target arithmetic sit outside. The surrounding datapath reads the hold, flush and bubble controls and drives the fetched instruction's fields and the branch outcome.

Top module: `pipe_stall_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every stage is empty: `pc_hold`, `ifid_hold`, `ifid_flush`, `idex_bubble`, `exe_valid` and `wb_valid` are all 0.
- R2: A valid decode instruction whose first source index is nonzero and equals the destination of a valid, writing instruction in execute, memory or writeback raises a stall in that cycle: `pc_hold`, `ifid_hold` and `idex_bubble` all read 1.
- R3: The second source index is checked against the same three stages in the same way, and a match on it alone is enough to stall.
- R4: A source index of 0 never causes a stall, even when an older writing instruction targets register 0.
- R5: An older instruction with write-enable clear (store, branch, bubble) never causes a stall, whatever its destination field holds.
- R6: During a stall the decode instruction and the presented fetch instruction are both held. `ifid_hold` equals `pc_hold`, and the held instruction is the next one to reach execute.
- R7: In the cycle after `idex_bubble` is 1, the execute stage is empty (`exe_valid` is 0).
- R8: When `ex_taken` is 1 and the execute stage holds a valid instruction, `ifid_flush` and `idex_bubble` are 1. In the next cycle both decode and execute are empty, so the instruction fetched in the flush cycle is dropped.
- R9: When a redirect and a data stall fall in the same cycle, the redirect wins: `pc_hold` and `ifid_hold` are 0.
- R10: `ex_taken` is ignored while the execute stage is empty: `ifid_flush` stays 0.
- R11: Instructions move from execute to writeback in exactly two cycles and in order: a valid `wb_tag` equals the `exe_tag` present two cycles earlier.
- R12: An empty writeback slot shows `wb_wen` = 0 and `wb_dst` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetched instruction present |
| if_tag | input | TAG_W | Trace tag of the fetched instruction |
| if_ra | input | IDX_W | First source register index |
| if_rb | input | IDX_W | Second source register index |
| if_rd | input | IDX_W | Destination register index |
| if_wen | input | 1 | Fetched instruction writes a register |
| ex_taken | input | 1 | Execute-stage redirect (taken branch or jump) |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Clear the fetch/decode register to a nop |
| idex_bubble | output | 1 | Load a nop into the decode/execute register |
| exe_valid | output | 1 | Execute stage holds an instruction |
| exe_tag | output | TAG_W | Tag of the execute-stage instruction |
| wb_valid | output | 1 | Writeback stage holds an instruction |
| wb_tag | output | TAG_W | Tag of the writeback-stage instruction |
| wb_dst | output | IDX_W | Destination of the writeback-stage instruction |
| wb_wen | output | 1 | Writeback-stage instruction writes a register |

## Verification
The hardest situation to reach is a taken redirect in execute while the decode instruction is also blocked by an older writer in memory or writeback, because the branch itself never writes. The stimulus draws register indices from a tiny set (0 to 3), so dependencies are dense. About one instruction in eight is a branch, taken half the time. A fixed directed prefix adds back-to-back dependencies, writes to register 0 and non-writing producers. A bench model of the stage slots predicts every control output each cycle, and the bench counts how often each corner case occurred so that a run that misses one is reported.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;

    // Number of stages behind decode that are compared against its sources
    localparam int unsigned N_LATE = 3;

    // Slot positions of the later stages in the comparator bank
    typedef enum logic [1:0] {
        LATE_EXE = 2'd0,
        LATE_MEM = 2'd1,
        LATE_WBK = 2'd2
    } late_stage_e;

    // Control bundle handed to the datapath
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic ifid_flush;
        logic idex_bubble;
    } hz_ctl_t;

endpackage

// File: rtl/src_match.sv
module src_match #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned N     = 3
) (
    input  logic [IDX_W-1:0]        src,
    input  logic [N-1:0][IDX_W-1:0] dst,
    input  logic [N-1:0]            wr,
    output logic                    hit
);
    logic [N-1:0] per_stage;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign per_stage[g] = wr[g] && (dst[g] == src);
    end

    // Register 0 is hard-wired and never owed by anyone
    assign hit = (src != '0) && (|per_stage);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import pipe_stall_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic                         dec_valid,
    input  logic [IDX_W-1:0]             dec_ra,
    input  logic [IDX_W-1:0]             dec_rb,
    input  logic [N_LATE-1:0][IDX_W-1:0] late_dst,
    input  logic [N_LATE-1:0]            late_wr,
    input  logic                         exe_valid,
    input  logic                         ex_taken,
    output hz_ctl_t                      ctl
);
    localparam int unsigned N_SRC = 2;

    logic [N_SRC-1:0][IDX_W-1:0] srcs;
    logic [N_SRC-1:0]            src_hit;
    logic                        raw;
    logic                        redirect;
    logic                        stall;

    assign srcs[0] = dec_ra;
    assign srcs[1] = dec_rb;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        src_match #(
            .IDX_W (IDX_W),
            .N     (N_LATE)
        ) i_match (
            .src (srcs[s]),
            .dst (late_dst),
            .wr  (late_wr),
            .hit (src_hit[s])
        );
    end

    always_comb begin
        raw      = dec_valid && (|src_hit);
        redirect = ex_taken && exe_valid;
        // A redirect discards the decode instruction, so its hazard is moot
        stall    = raw && !redirect;

        ctl.pc_hold     = stall;
        ctl.ifid_hold   = stall;
        ctl.ifid_flush  = redirect;
        ctl.idex_bubble = stall || redirect;
    end
endmodule

// File: rtl/pipe_stall_ctl.sv
module pipe_stall_ctl
    import pipe_stall_pkg::*;
#(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_valid,
    input  logic [TAG_W-1:0] if_tag,
    input  logic [IDX_W-1:0] if_ra,
    input  logic [IDX_W-1:0] if_rb,
    input  logic [IDX_W-1:0] if_rd,
    input  logic             if_wen,
    input  logic             ex_taken,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             ifid_flush,
    output logic             idex_bubble,
    output logic             exe_valid,
    output logic [TAG_W-1:0] exe_tag,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [IDX_W-1:0] wb_dst,
    output logic             wb_wen
);
    typedef struct packed {
        logic             valid;
        logic             wen;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic [TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        slot_t dec;
        slot_t exe;
        slot_t mem;
        slot_t wbk;
    } pipe_t;

    // Bubble: not valid, no write, destination 0
    localparam slot_t NOP_SLOT = '0;

    pipe_t   pipe_d, pipe_q;
    slot_t   fetch_slot;
    hz_ctl_t ctl;

    logic [N_LATE-1:0][IDX_W-1:0] late_dst;
    logic [N_LATE-1:0]            late_wr;

    always_comb begin
        late_dst[LATE_EXE] = pipe_q.exe.dst;
        late_dst[LATE_MEM] = pipe_q.mem.dst;
        late_dst[LATE_WBK] = pipe_q.wbk.dst;
        late_wr[LATE_EXE]  = pipe_q.exe.valid && pipe_q.exe.wen;
        late_wr[LATE_MEM]  = pipe_q.mem.valid && pipe_q.mem.wen;
        late_wr[LATE_WBK]  = pipe_q.wbk.valid && pipe_q.wbk.wen;
    end

    hazard_unit #(
        .IDX_W (IDX_W)
    ) i_hazard (
        .dec_valid (pipe_q.dec.valid),
        .dec_ra    (pipe_q.dec.ra),
        .dec_rb    (pipe_q.dec.rb),
        .late_dst  (late_dst),
        .late_wr   (late_wr),
        .exe_valid (pipe_q.exe.valid),
        .ex_taken  (ex_taken),
        .ctl       (ctl)
    );

    always_comb begin
        fetch_slot = NOP_SLOT;
        if (if_valid) begin
            fetch_slot.valid = 1'b1;
            fetch_slot.wen   = if_wen;
            fetch_slot.dst   = if_rd;
            fetch_slot.ra    = if_ra;
            fetch_slot.rb    = if_rb;
            fetch_slot.tag   = if_tag;
        end

        pipe_d     = pipe_q;
        pipe_d.wbk = pipe_q.mem;
        pipe_d.mem = pipe_q.exe;
        pipe_d.exe = ctl.idex_bubble ? NOP_SLOT : pipe_q.dec;
        if (ctl.ifid_flush) begin
            pipe_d.dec = NOP_SLOT;
        end else if (!ctl.ifid_hold) begin
            pipe_d.dec = fetch_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign pc_hold     = ctl.pc_hold;
    assign ifid_hold   = ctl.ifid_hold;
    assign ifid_flush  = ctl.ifid_flush;
    assign idex_bubble = ctl.idex_bubble;
    assign exe_valid   = pipe_q.exe.valid;
    assign exe_tag     = pipe_q.exe.tag;
    assign wb_valid    = pipe_q.wbk.valid;
    assign wb_tag      = pipe_q.wbk.tag;
    assign wb_dst      = pipe_q.wbk.dst;
    assign wb_wen      = pipe_q.wbk.wen;
endmodule

// File: rtl/pipe_stall_chk.sv
module pipe_stall_chk #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ex_taken,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             ifid_flush,
    input logic             idex_bubble,
    input logic             exe_valid,
    input logic [TAG_W-1:0] exe_tag,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic [IDX_W-1:0] wb_dst,
    input logic             wb_wen
);
    // R9
    flush_beats_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (!pc_hold && !ifid_hold));

    // R8
    flush_empties_exe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |=> !exe_valid);

    // R7
    bubble_empties_exe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !exe_valid);

    // R10
    idle_taken_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_taken && !exe_valid) |-> !ifid_flush);

    // R11
    exe_to_wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(exe_valid, 2) && (wb_tag == $past(exe_tag, 2))));

    // R12
    empty_wb_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> (!wb_wen && (wb_dst == '0)));
endmodule

bind pipe_stall_ctl pipe_stall_chk #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
) i_pipe_stall_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_taken    (ex_taken),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ifid_flush  (ifid_flush),
    .idex_bubble (idex_bubble),
    .exe_valid   (exe_valid),
    .exe_tag     (exe_tag),
    .wb_valid    (wb_valid),
    .wb_tag      (wb_tag),
    .wb_dst      (wb_dst),
    .wb_wen      (wb_wen)
);

// File: tb/test_pipe_stall_ctl.sv
`timescale 1ns/1ps
module test_pipe_stall_ctl;
    localparam int IW = 5;
    localparam int TW = 8;
    localparam int PROG = 256;
    localparam int CYCLES = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_valid = 1'b0;
    logic [TW-1:0] if_tag = '0;
    logic [IW-1:0] if_ra = '0, if_rb = '0, if_rd = '0;
    logic          if_wen = 1'b0;
    logic          ex_taken = 1'b0;
    logic          pc_hold, ifid_hold, ifid_flush, idex_bubble;
    logic          exe_valid, wb_valid, wb_wen;
    logic [TW-1:0] exe_tag, wb_tag;
    logic [IW-1:0] wb_dst;

    always #2 clk = ~clk;

    pipe_stall_ctl #(.IDX_W(IW), .TAG_W(TW)) i_pipe_stall_ctl (
        .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_tag(if_tag),
        .if_ra(if_ra), .if_rb(if_rb), .if_rd(if_rd), .if_wen(if_wen),
        .ex_taken(ex_taken), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .ifid_flush(ifid_flush), .idex_bubble(idex_bubble),
        .exe_valid(exe_valid), .exe_tag(exe_tag), .wb_valid(wb_valid),
        .wb_tag(wb_tag), .wb_dst(wb_dst), .wb_wen(wb_wen)
    );

    // Program trace
    logic [IW-1:0] p_ra[PROG], p_rb[PROG], p_rd[PROG];
    logic          p_wen[PROG], p_br[PROG];
    logic [TW-1:0] p_tgt[PROG];

    // Model slots: 0 decode, 1 execute, 2 memory, 3 writeback
    logic          mv[4], mw[4];
    logic [IW-1:0] md[4], ma, mb;
    logic [TW-1:0] mt[4];
    logic [TW-1:0] pc;

    int n_tests = 0, n_fail = 0;
    int n_both = 0, n_zero = 0, n_rbonly = 0, n_nowen = 0, n_idle = 0, n_stall = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic src_owed(input logic [IW-1:0] s);
        logic h = 1'b0;
        for (int k = 1; k < 4; k++)
            if (s != '0 && mv[k] && mw[k] && md[k] == s) h = 1'b1;
        return h;
    endfunction

    function automatic logic zero_writer();
        logic h = 1'b0;
        for (int k = 1; k < 4; k++)
            if (mv[k] && mw[k] && md[k] == '0) h = 1'b1;
        return h;
    endfunction

    function automatic logic silent_match(input logic [IW-1:0] s);
        logic h = 1'b0;
        for (int k = 1; k < 4; k++)
            if (s != '0 && mv[k] && !mw[k] && md[k] == s) h = 1'b1;
        return h;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            mv[k] = 1'b0; mw[k] = 1'b0; md[k] = '0; mt[k] = '0;
        end
        ma = '0; mb = '0; pc = '0;
    endtask

    task automatic one_cycle(input logic fetch_on);
        logic  haz, redir, stall;
        string tag;
        @(negedge clk);
        if_valid = fetch_on;
        if_tag   = pc;
        if_ra    = p_ra[pc];
        if_rb    = p_rb[pc];
        if_rd    = p_rd[pc];
        if_wen   = p_wen[pc];
        if (mv[1]) ex_taken = p_br[mt[1]];
        else       ex_taken = ($urandom_range(0, 3) == 0);
        haz   = mv[0] && (src_owed(ma) || src_owed(mb));
        redir = ex_taken && mv[1];
        stall = haz && !redir;
        #1;
        if (haz && redir) begin tag = "R9"; n_both++; end
        else if (ex_taken && !mv[1]) begin tag = "R10"; n_idle++; end
        else if (mv[0] && !haz && (ma == '0 || mb == '0) && zero_writer()) begin tag = "R4"; n_zero++; end
        else if (mv[0] && !haz && (silent_match(ma) || silent_match(mb))) begin tag = "R5"; n_nowen++; end
        else if (haz && !src_owed(ma)) begin tag = "R3"; n_rbonly++; end
        else tag = "R2";
        if (stall) n_stall++;
        check(pc_hold == stall, tag, pc_hold, stall);
        check(ifid_hold == stall, "R6", ifid_hold, stall);
        check(ifid_flush == redir, redir ? "R8" : "R10", ifid_flush, redir);
        check(idex_bubble == (stall || redir), "R7", idex_bubble, stall || redir);
        check(exe_valid == mv[1], "R11", exe_valid, mv[1]);
        if (mv[1]) check(exe_tag == mt[1], "R11", exe_tag, mt[1]);
        check(wb_valid == mv[3], "R11", wb_valid, mv[3]);
        if (mv[3]) begin
            check(wb_tag == mt[3], "R11", wb_tag, mt[3]);
            check(wb_dst == md[3], "R11", wb_dst, md[3]);
        end else begin
            check(wb_dst == '0 && !wb_wen, "R12", {wb_wen, wb_dst}, 0);
        end
        // advance model
        mv[3] = mv[2]; mw[3] = mw[2]; md[3] = md[2]; mt[3] = mt[2];
        mv[2] = mv[1]; mw[2] = mw[1]; md[2] = md[1]; mt[2] = mt[1];
        if (stall || redir) begin
            mv[1] = 1'b0; mw[1] = 1'b0; md[1] = '0; mt[1] = '0;
        end else begin
            mv[1] = mv[0]; mw[1] = mw[0]; md[1] = md[0]; mt[1] = mt[0];
        end
        if (redir) begin
            mv[0] = 1'b0; mw[0] = 1'b0; md[0] = '0; mt[0] = '0; ma = '0; mb = '0;
            pc = p_tgt[mt[2]];
        end else if (!stall) begin
            if (fetch_on) begin
                mv[0] = 1'b1; mw[0] = p_wen[pc]; md[0] = p_rd[pc]; mt[0] = pc;
                ma = p_ra[pc]; mb = p_rb[pc];
                pc = pc + 1'b1;
            end else begin
                mv[0] = 1'b0; mw[0] = 1'b0; md[0] = '0; mt[0] = '0; ma = '0; mb = '0;
            end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4410));
        for (int i = 0; i < PROG; i++) begin
            p_br[i]  = ($urandom_range(0, 7) == 0) && ($urandom_range(0, 1) == 1);
            p_wen[i] = p_br[i] ? 1'b0 : ($urandom_range(0, 3) != 0);
            p_ra[i]  = IW'($urandom_range(0, 3));
            p_rb[i]  = IW'($urandom_range(0, 3));
            p_rd[i]  = IW'($urandom_range(0, 3));
            p_tgt[i] = TW'($urandom_range(0, PROG - 1));
        end
        // directed prefix: back-to-back RAW, r0 writer, silent producer, rb-only, branch
        for (int i = 0; i < 10; i++) begin
            p_br[i] = 1'b0; p_wen[i] = 1'b0; p_ra[i] = '0; p_rb[i] = '0; p_rd[i] = '0;
        end
        p_rd[0] = 5'd1; p_wen[0] = 1'b1;
        p_ra[1] = 5'd1;
        p_rd[2] = 5'd0; p_wen[2] = 1'b1;
        p_ra[3] = 5'd0; p_rb[3] = 5'd0;
        p_rd[4] = 5'd2;
        p_rb[5] = 5'd2;
        p_rd[6] = 5'd3; p_wen[6] = 1'b1;
        p_rb[7] = 5'd3;
        p_rd[8] = 5'd1; p_wen[8] = 1'b1;
        p_br[9] = 1'b1; p_ra[9] = 5'd1; p_tgt[9] = 8'd40;

        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        check({pc_hold, ifid_hold, ifid_flush, idex_bubble, exe_valid, wb_valid} == '0,
              "R1", {pc_hold, ifid_hold, ifid_flush, idex_bubble, exe_valid, wb_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({pc_hold, ifid_hold, ifid_flush, idex_bubble, exe_valid, wb_valid} == '0,
              "R1", {pc_hold, ifid_hold, ifid_flush, idex_bubble, exe_valid, wb_valid}, 0);
        for (int c = 0; c < CYCLES; c++)
            one_cycle((c < 20) || ($urandom_range(0, 9) != 0));
        // corner cases must have been reached
        check(n_both > 0, "R9", n_both, 1);
        check(n_zero > 0, "R4", n_zero, 1);
        check(n_nowen > 0, "R5", n_nowen, 1);
        check(n_rbonly > 0, "R3", n_rbonly, 1);
        check(n_idle > 0, "R10", n_idle, 1);
        check(n_stall > 0, "R2", n_stall, 1);
        finish_run();
    end
endmodule